// File: doc/BRIEF.md
# PS/2 Mouse Cursor Position Tracker

This block sits behind a PS/2 receiver that has already removed the start, parity and stop bits from the serial line. Each received byte arrives on a valid strobe. The block groups these bytes into three-byte mouse reports. The first byte of a report carries the buttons and the sign bits. The second byte carries horizontal motion and the third carries vertical motion. The block keeps a resync rule on the first byte, so a lost byte cannot leave every later report misaligned.

Each report's relative motion is added to an absolute cursor position, and that position is clamped to a 640 by 480 screen. Screen rows count downward while the mouse reports upward motion as positive, so vertical motion is subtracted from the row. When a report completes, the block raises a single-cycle strobe. The new position and button state stay on the outputs until the next report, so a drawing engine can read them whenever it likes. A held-left output and a click pulse let that engine join successive positions with line segments.

Top module: `ps2_cursor_tracker`

## Requirements
- R1: After a synchronous active-low reset, the cursor is at column 320, row 240. Both buttons, the held output, the click pulse and the report strobe are low.
- R2: A report is three accepted bytes in order: status, horizontal motion, vertical motion. `rpt_valid` is high for exactly one cycle, in the cycle after the clock edge that accepts the third byte. It is never high in two consecutive cycles.
- R3: A byte offered as the status byte with bit 3 clear is dropped. The next accepted byte is again treated as a status byte, so no report is produced from it.
- R4: Horizontal motion is a 9-bit two's-complement value. Status bit 4 is its sign and the second byte gives its low eight bits. This value is added to the column.
- R5: Vertical motion is a 9-bit two's-complement value. Status bit 5 is its sign and the third byte gives its low eight bits. This value is subtracted from the row.
- R6: The column saturates at 0 and at 639.
- R7: The row saturates at 0 and at 479.
- R8: `btn_left` is status bit 0 and `btn_right` is status bit 1 of the latest report, with 1 meaning pressed.
- R9: `left_click` is high for one cycle, together with `rpt_valid`, on a report whose left bit is 1 when the previous report's left bit was 0.
- R10: `left_held` is high from a report whose left bit is 1 while the previous report's left bit was also 1. It stays high until the next report.
- R11: Between reports the position and button outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_valid | input | 1 | A deframed byte is present this cycle |
| rx_byte | input | 8 | Deframed byte from the PS/2 receiver |
| rpt_valid | output | 1 | One-cycle strobe per completed report |
| cur_col | output | 10 | Cursor column, 0 to 639 |
| cur_row | output | 9 | Cursor row, 0 to 479 |
| btn_left | output | 1 | Left button pressed in the latest report |
| btn_right | output | 1 | Right button pressed in the latest report |
| left_held | output | 1 | Left button pressed in this and the previous report |
| left_click | output | 1 | One-cycle pulse on a left press |

## Verification
The bench drives both small positive and small negative motion. This shows that the sign bits come from the status byte and that the vertical axis is inverted. Repeated full-scale moves toward each edge, including the -256 extreme, separate correct saturation from wrap-around on both axes. A press, hold and release sequence separates the click pulse from the held output. Stray status-slot bytes with bit 3 clear, and reports sent with idle gaps between bytes, show whether alignment is kept. Idle stretches after reports confirm that the outputs hold.

// File: rtl/cursor_pkg.sv
// Shared types and constants for the PS/2 cursor tracker.
// Assumes the standard three-byte mouse report layout.
package cursor_pkg;

    localparam int BYTE_W    = 8;
    localparam int DELTA_W   = 9;
    localparam int BIT_LEFT  = 0;
    localparam int BIT_RIGHT = 1;
    localparam int BIT_SYNC  = 3;
    localparam int BIT_XSIGN = 4;
    localparam int BIT_YSIGN = 5;

    // One decoded report
    typedef struct packed {
        logic                      left;
        logic                      right;
        logic signed [DELTA_W-1:0] dx;
        logic signed [DELTA_W-1:0] dy;
    } mouse_rpt_t;

    typedef enum logic [1:0] {
        SLOT_STATUS = 2'd0,
        SLOT_XMOVE  = 2'd1,
        SLOT_YMOVE  = 2'd2
    } slot_e;

endpackage

// File: rtl/report_assembler.sv
// Groups deframed bytes into three-byte mouse reports and decodes them.
// Assumes the bytes arrive in order. A status-slot byte with its sync bit
// clear is dropped so that alignment recovers after a lost byte.
module report_assembler
    import cursor_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_byte,
    output logic              rpt_done,
    output mouse_rpt_t        rpt
);

    slot_e             slot_q;
    logic [BYTE_W-1:0] status_q;
    logic [BYTE_W-1:0] xbyte_q;

    // Advance the slot pointer and capture the first two bytes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q   <= SLOT_STATUS;
            status_q <= '0;
            xbyte_q  <= '0;
        end else if (rx_valid) begin
            unique case (slot_q)
                SLOT_STATUS: begin
                    if (rx_byte[BIT_SYNC]) begin
                        status_q <= rx_byte;
                        slot_q   <= SLOT_XMOVE;
                    end
                end
                SLOT_XMOVE: begin
                    xbyte_q <= rx_byte;
                    slot_q  <= SLOT_YMOVE;
                end
                SLOT_YMOVE: slot_q <= SLOT_STATUS;
                default:    slot_q <= SLOT_STATUS;
            endcase
        end
    end

    // Report completes when the third byte is offered
    always_comb rpt_done = rx_valid && (slot_q == SLOT_YMOVE);

    // Decode buttons and sign-extended motion
    always_comb begin
        rpt.left  = status_q[BIT_LEFT];
        rpt.right = status_q[BIT_RIGHT];
        rpt.dx    = $signed({status_q[BIT_XSIGN], xbyte_q});
        rpt.dy    = $signed({status_q[BIT_YSIGN], rx_byte});
    end

    // R3
    resync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && slot_q == SLOT_STATUS && !rx_byte[BIT_SYNC]) |=> slot_q == SLOT_STATUS);

    // R2
    order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && slot_q == SLOT_XMOVE) |=> slot_q == SLOT_YMOVE);

endmodule

// File: rtl/axis_accum.sv
// One saturating position counter for a single screen axis.
// Assumes that MAX_POS fits in W bits and that INIT_POS <= MAX_POS.
// INVERT selects whether the motion is subtracted (used for rows) or added.
module axis_accum
    import cursor_pkg::*;
#(
    parameter int W        = 10,
    parameter int MAX_POS  = 639,
    parameter int INIT_POS = 320,
    parameter bit INVERT   = 1'b0
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      upd,
    input  logic signed [DELTA_W-1:0] delta,
    output logic [W-1:0]              pos
);

    localparam int SW = ((W > DELTA_W) ? W : DELTA_W) + 2;
    localparam logic signed [SW-1:0] LIMIT = SW'(MAX_POS);

    logic [W-1:0]          pos_q;
    logic signed [SW-1:0]  base;
    logic signed [SW-1:0]  step;
    logic signed [SW-1:0]  sum;
    logic [W-1:0]          clamped;

    // Widen the current position and the motion to a common signed width
    always_comb begin
        base = $signed({{(SW-W){1'b0}}, pos_q});
        step = $signed({{(SW-DELTA_W){delta[DELTA_W-1]}}, delta});
    end

    generate
        if (INVERT) begin : g_sub
            // Axis counts against the mouse direction
            always_comb sum = base - step;
        end else begin : g_add
            // Axis counts with the mouse direction
            always_comb sum = base + step;
        end
    endgenerate

    // Saturate the raw sum to the screen range
    always_comb begin
        if (sum < 0)
            clamped = '0;
        else if (sum > LIMIT)
            clamped = W'(MAX_POS);
        else
            clamped = sum[W-1:0];
    end

    // Hold position, load the clamped sum on each report
    always_ff @(posedge clk) begin
        if (!rst_n)
            pos_q <= W'(INIT_POS);
        else if (upd)
            pos_q <= clamped;
    end

    always_comb pos = pos_q;

    // R6 R7
    bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pos_q <= W'(MAX_POS));

    // R11
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !upd |=> $stable(pos_q));

endmodule

// File: rtl/button_tracker.sv
// Keeps the button state of the latest report and derives the held level
// and the press pulse for the left button. Assumes upd is a single-cycle strobe.
module button_tracker
    import cursor_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic upd,
    input  logic left_in,
    input  logic right_in,
    output logic left,
    output logic right,
    output logic held,
    output logic click
);

    logic left_q, right_q, held_q, click_q;

    // Register buttons per report; the click lasts one cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_q  <= 1'b0;
            right_q <= 1'b0;
            held_q  <= 1'b0;
            click_q <= 1'b0;
        end else if (upd) begin
            left_q  <= left_in;
            right_q <= right_in;
            held_q  <= left_in & left_q;
            click_q <= left_in & ~left_q;
        end else begin
            click_q <= 1'b0;
        end
    end

    always_comb begin
        left  = left_q;
        right = right_q;
        held  = held_q;
        click = click_q;
    end

    // R9
    click_press_chk: assert property (@(posedge clk) disable iff (!rst_n)
        click_q |-> (left_q && !held_q));

    // R9
    click_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        click_q |=> !click_q);

    // R10
    held_left_chk: assert property (@(posedge clk) disable iff (!rst_n)
        held_q |-> left_q);

endmodule

// File: rtl/ps2_cursor_tracker.sv
// Top: assembles PS/2 mouse reports, tracks a clamped absolute cursor and
// reports buttons. Assumes an upstream receiver that delivers one deframed
// byte per rx_valid cycle.
module ps2_cursor_tracker
    import cursor_pkg::*;
#(
    parameter int SCREEN_W = 640,
    parameter int SCREEN_H = 480,
    parameter int COL_W    = $clog2(SCREEN_W),
    parameter int ROW_W    = $clog2(SCREEN_H)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [7:0]        rx_byte,
    output logic              rpt_valid,
    output logic [COL_W-1:0]  cur_col,
    output logic [ROW_W-1:0]  cur_row,
    output logic              btn_left,
    output logic              btn_right,
    output logic              left_held,
    output logic              left_click
);

    localparam int COL_MAX = SCREEN_W - 1;
    localparam int ROW_MAX = SCREEN_H - 1;

    logic       rpt_done;
    mouse_rpt_t rpt;
    logic       rpt_valid_q;

    report_assembler u_asm (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_valid (rx_valid),
        .rx_byte  (rx_byte),
        .rpt_done (rpt_done),
        .rpt      (rpt)
    );

    axis_accum #(
        .W(COL_W), .MAX_POS(COL_MAX), .INIT_POS(SCREEN_W / 2), .INVERT(1'b0)
    ) u_col (
        .clk   (clk),
        .rst_n (rst_n),
        .upd   (rpt_done),
        .delta (rpt.dx),
        .pos   (cur_col)
    );

    axis_accum #(
        .W(ROW_W), .MAX_POS(ROW_MAX), .INIT_POS(SCREEN_H / 2), .INVERT(1'b1)
    ) u_row (
        .clk   (clk),
        .rst_n (rst_n),
        .upd   (rpt_done),
        .delta (rpt.dy),
        .pos   (cur_row)
    );

    button_tracker u_btn (
        .clk      (clk),
        .rst_n    (rst_n),
        .upd      (rpt_done),
        .left_in  (rpt.left),
        .right_in (rpt.right),
        .left     (btn_left),
        .right    (btn_right),
        .held     (left_held),
        .click    (left_click)
    );

    // Align the report strobe with the updated outputs
    always_ff @(posedge clk) begin
        if (!rst_n) rpt_valid_q <= 1'b0;
        else        rpt_valid_q <= rpt_done;
    end

    always_comb rpt_valid = rpt_valid_q;

    // R2
    single_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rpt_valid_q |=> !rpt_valid_q);

    // R9
    click_with_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        left_click |-> rpt_valid_q);

    // R11
    btn_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rpt_done |=> ($stable(btn_left) && $stable(btn_right) && $stable(left_held)));

endmodule

// File: tb/ps2_cursor_tracker_tb.sv
module ps2_cursor_tracker_tb;

    typedef struct {
        int col;
        int row;
        int l;
        int r;
        int held;
        int click;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_byte = 8'h00;
    logic       rpt_valid;
    logic [9:0] cur_col;
    logic [8:0] cur_row;
    logic       btn_left, btn_right, left_held, left_click;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    exp_t sb[$];

    // model state
    int mcol = 320;
    int mrow = 240;
    int mprev_l = 0;

    always #2 clk = ~clk;   // 250 MHz

    ps2_cursor_tracker u_dut (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .rpt_valid(rpt_valid), .cur_col(cur_col), .cur_row(cur_row),
        .btn_left(btn_left), .btn_right(btn_right),
        .left_held(left_held), .left_click(left_click)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int clamp(input int v, input int hi);
        if (v < 0) return 0;
        if (v > hi) return hi;
        return v;
    endfunction

    task automatic send_byte(input logic [7:0] b, input int gap);
        @(negedge clk);
        rx_valid = 1'b1;
        rx_byte  = b;
        @(negedge clk);
        rx_valid = 1'b0;
        repeat (gap) @(negedge clk);
    endtask

    // Driver: model the report, push the expectation, drive the bytes
    task automatic send_report(input logic [7:0] st, input logic [7:0] xb,
                               input logic [7:0] yb, input int gap);
        exp_t e;
        int dx, dy;
        dx = st[4] ? int'(xb) - 256 : int'(xb);   // R4
        dy = st[5] ? int'(yb) - 256 : int'(yb);   // R5
        mcol = clamp(mcol + dx, 639);             // R6
        mrow = clamp(mrow - dy, 479);             // R7
        e.col = mcol;
        e.row = mrow;
        e.l = int'(st[0]);
        e.r = int'(st[1]);
        e.held  = (st[0] && mprev_l) ? 1 : 0;
        e.click = (st[0] && !mprev_l) ? 1 : 0;
        mprev_l = int'(st[0]);
        send_byte(st, gap);
        send_byte(xb, gap);
        sb.push_back(e);
        @(negedge clk);
        rx_valid = 1'b1;
        rx_byte  = yb;
        @(negedge clk);
        rx_valid = 1'b0;
        check("R2 strobe after third byte", int'(rpt_valid), 1);
        @(negedge clk);
        check("R2 strobe one cycle", int'(rpt_valid), 0);
        check("R9 click one cycle", int'(left_click), 0);
        repeat (gap) @(negedge clk);
    endtask

    // Monitor: pop and compare on each report strobe
    always @(negedge clk) begin
        if (rst_n && rpt_valid) begin
            if (sb.size() == 0) begin
                check("R2 R3 unexpected report", 1, 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check("R4 R6 column", int'(cur_col), e.col);
                check("R5 R7 row", int'(cur_row), e.row);
                check("R8 left", int'(btn_left), e.l);
                check("R8 right", int'(btn_right), e.r);
                check("R10 held", int'(left_held), e.held);
                check("R9 click", int'(left_click), e.click);
            end
        end
    end

    task automatic idle_hold(input int n);
        repeat (n) @(negedge clk);
        check("R11 column holds", int'(cur_col), mcol);
        check("R11 row holds", int'(cur_row), mrow);
        check("R11 left holds", int'(btn_left), mprev_l);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R1 reset state
        check("R1 column", int'(cur_col), 320);
        check("R1 row", int'(cur_row), 240);
        check("R1 buttons", int'({btn_left, btn_right, left_held, left_click}), 0);
        check("R1 strobe", int'(rpt_valid), 0);
        rst_n = 1'b1;
        idle_hold(3);

        // R4 R5 small positive then negative motion
        send_report(8'h08, 8'd10, 8'd5, 0);
        send_report(8'h38, 8'hF6, 8'hFB, 2);
        idle_hold(5);

        // R8 R9 R10 press, hold, release with right
        send_report(8'h09, 8'd0, 8'd0, 0);
        send_report(8'h09, 8'd1, 8'd1, 1);
        send_report(8'h09, 8'd0, 8'd0, 0);
        send_report(8'h0A, 8'd0, 8'd0, 0);
        send_report(8'h09, 8'd2, 8'd0, 3);
        idle_hold(4);

        // R6 right edge, then -256 to left edge
        for (int i = 0; i < 4; i++) send_report(8'h08, 8'd127, 8'd0, 0);
        for (int i = 0; i < 3; i++) send_report(8'h18, 8'h00, 8'd0, 0);
        // R7 top edge, then -256 to bottom edge
        for (int i = 0; i < 3; i++) send_report(8'h08, 8'd0, 8'd127, 0);
        for (int i = 0; i < 2; i++) send_report(8'h28, 8'd0, 8'h00, 0);
        idle_hold(3);

        // R3 stray bytes with bit 3 clear are dropped
        send_byte(8'h00, 0);
        send_byte(8'hF7, 1);
        idle_hold(3);
        send_report(8'h1A, 8'hFB, 8'd3, 0);
        send_byte(8'h01, 0);
        send_report(8'h08, 8'd4, 8'd0, 1);
        idle_hold(6);
        check("R2 all reports seen", sb.size(), 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule